// File: doc/BRIEF.md
# Holdable Boolean Demultiplexer

This block steers one data bit onto one of `NUM_OUT` output lines, where `NUM_OUT` is at most 16. A binary address picks the line. When the data bit is false, all lines are false. When the data bit is tied true, the block works as a binary-to-one-hot decoder.

Two clocked hold stages sit around the decoder, and each has its own enable.

- **Address stage.** It can freeze the address that feeds the decoder. It works in one of two modes:
  - Level mode: the address tracks the pins while the enable is high and keeps its last value while the enable is low.
  - Rising mode: the address is captured only at the clock edge where the enable first goes high.
- **Output stage.** While its enable is low, it freezes the whole output vector. A decoded pattern can therefore be kept while the address and the data move on.

Both stages are registers, not transparent latches. Either stage can be removed by a parameter. Every pin has its own polarity parameter.

The data and the outputs are single bits that are valid on every cycle. The block has no valid/ready handshake and never applies back-pressure. Because of that, no stream rules apply at its edge.

Top module: `bdemux`

## Requirements
- R1: When the logical data input is 0 and the output enable is high, all logical outputs are 0 in the same cycle, whatever the address.
- R2: When the logical data input is 1, the output enable is high and the effective address `a` is below `NUM_OUT`, only logical output bit `a` is 1. The address is plain binary with `addr[0]` as its least significant bit.
- R3: When the effective address is `NUM_OUT` or above, all logical outputs are 0.
- R4: In level mode (`ADDR_MODE = ADDR_LEVEL`), the address applies combinationally while the address enable is high. While the enable is low, the decoder uses the address sampled at the last clock edge where the enable was high.
- R5: In rising mode (`ADDR_MODE = ADDR_RISE`), the held address loads at a clock edge where the enable is high and was low at the previous edge. The decoder uses only the held address, so a newly loaded value takes effect after that edge.
- R6: While the output enable is high, the outputs follow the decoder combinationally. While it is low, the outputs show the vector that was present at the last clock edge where the enable was high.
- R7: With `USE_OUT_HOLD = 0`, `out_en` has no effect and the outputs always follow the decoder.
- R8: Parameters `INV_DIN`, `INV_ADDR`, `INV_AEN`, `INV_OEN` and `INV_DOUT` invert, bit by bit, the matching pin relative to its logical signal.
- R9: A clock edge with `rst_n` low clears the held address to 0, clears the held output vector to all 0, and clears the rising-mode edge history.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| din | input | 1 | Data bit to route |
| addr | input | ADDR_W | Output select, binary |
| addr_en | input | 1 | Address track/hold enable |
| out_en | input | 1 | Output track/hold enable |
| dout | output | NUM_OUT | Routed outputs |

## Verification
The decoder is checked by sweeping the full address range with the data bit high, which separates correct line selection from out-of-range blanking. The same sweep with the data bit low shows that no line ever leaks through. Hold behaviour is tested by dropping one enable and then moving the address and the data underneath it. A frozen result can then be told apart from a live one.

A second instance runs in rising mode, with output hold removed and inverted data and outputs. The same stimulus therefore also separates capture on an edge from capture on a level, and shows that `out_en` is ignored when the output stage is bypassed. A final stretch of pseudo-random stimulus mixes all of these conditions.

// File: rtl/bdemux_pkg.sv
package bdemux_pkg;
  typedef enum logic { ADDR_LEVEL = 1'b0, ADDR_RISE = 1'b1 } addr_mode_e;
  localparam int MAX_OUT = 16;
endpackage

// File: rtl/bdemux_addr_stage.sv
module bdemux_addr_stage
  import bdemux_pkg::*;
#(
  parameter int         ADDR_W = 4,
  parameter bit         ENABLE = 1'b1,
  parameter addr_mode_e MODE   = ADDR_LEVEL
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic              en,
  output logic [ADDR_W-1:0] addr_eff
);
  generate
    if (!ENABLE) begin : g_bypass
      assign addr_eff = addr_in;
    end else if (MODE == ADDR_LEVEL) begin : g_level
      logic [ADDR_W-1:0] held_q;
      always_ff @(posedge clk) begin
        if (!rst_n)  held_q <= '0;
        else if (en) held_q <= addr_in;
      end
      assign addr_eff = en ? addr_in : held_q;
    end else begin : g_rise
      logic [ADDR_W-1:0] held_q;
      logic              en_d;
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          held_q <= '0;
          en_d   <= 1'b0;
        end else begin
          en_d <= en;
          if (en && !en_d) held_q <= addr_in;
        end
      end
      assign addr_eff = held_q;
    end
  endgenerate
endmodule

// File: rtl/bdemux_decode.sv
module bdemux_decode #(
  parameter int ADDR_W  = 4,
  parameter int NUM_OUT = 12
) (
  input  logic               din,
  input  logic [ADDR_W-1:0]  addr,
  output logic [NUM_OUT-1:0] lines
);
  for (genvar i = 0; i < NUM_OUT; i++) begin : g_line
    assign lines[i] = din & (addr == ADDR_W'(i));
  end
endmodule

// File: rtl/bdemux_out_stage.sv
module bdemux_out_stage #(
  parameter int NUM_OUT = 12,
  parameter bit ENABLE  = 1'b1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               en,
  input  logic [NUM_OUT-1:0] live,
  output logic [NUM_OUT-1:0] vec
);
  generate
    if (!ENABLE) begin : g_bypass
      assign vec = live;
    end else begin : g_hold
      logic [NUM_OUT-1:0] held_q;
      always_ff @(posedge clk) begin
        if (!rst_n)  held_q <= '0;
        else if (en) held_q <= live;
      end
      assign vec = en ? live : held_q;
    end
  endgenerate
endmodule

// File: rtl/bdemux.sv
module bdemux
  import bdemux_pkg::*;
#(
  parameter int                 NUM_OUT       = 12,
  parameter int                 ADDR_W        = 4,
  parameter bit                 USE_ADDR_HOLD = 1'b1,
  parameter bit                 USE_OUT_HOLD  = 1'b1,
  parameter addr_mode_e         ADDR_MODE     = ADDR_LEVEL,
  parameter bit                 INV_DIN       = 1'b0,
  parameter logic [ADDR_W-1:0]  INV_ADDR      = '0,
  parameter bit                 INV_AEN       = 1'b0,
  parameter bit                 INV_OEN       = 1'b0,
  parameter logic [NUM_OUT-1:0] INV_DOUT      = '0
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               din,
  input  logic [ADDR_W-1:0]  addr,
  input  logic               addr_en,
  input  logic               out_en,
  output logic [NUM_OUT-1:0] dout
);
  logic               din_l, aen_l, oen_l;
  logic [ADDR_W-1:0]  addr_l, addr_eff;
  logic [NUM_OUT-1:0] lines, vec;

  assign din_l  = din ^ INV_DIN;
  assign addr_l = addr ^ INV_ADDR;
  assign aen_l  = addr_en ^ INV_AEN;
  assign oen_l  = out_en ^ INV_OEN;

  bdemux_addr_stage #(.ADDR_W(ADDR_W), .ENABLE(USE_ADDR_HOLD), .MODE(ADDR_MODE)) u_addr (
    .clk(clk), .rst_n(rst_n), .addr_in(addr_l), .en(aen_l), .addr_eff(addr_eff)
  );

  bdemux_decode #(.ADDR_W(ADDR_W), .NUM_OUT(NUM_OUT)) u_dec (
    .din(din_l), .addr(addr_eff), .lines(lines)
  );

  bdemux_out_stage #(.NUM_OUT(NUM_OUT), .ENABLE(USE_OUT_HOLD)) u_out (
    .clk(clk), .rst_n(rst_n), .en(oen_l), .live(lines), .vec(vec)
  );

  assign dout = vec ^ INV_DOUT;
endmodule

// File: rtl/bdemux_chk.sv
module bdemux_chk
  import bdemux_pkg::*;
#(
  parameter int                 NUM_OUT       = 12,
  parameter int                 ADDR_W        = 4,
  parameter bit                 USE_ADDR_HOLD = 1'b1,
  parameter bit                 USE_OUT_HOLD  = 1'b1,
  parameter addr_mode_e         ADDR_MODE     = ADDR_LEVEL,
  parameter bit                 INV_DIN       = 1'b0,
  parameter bit                 INV_AEN       = 1'b0,
  parameter bit                 INV_OEN       = 1'b0,
  parameter logic [NUM_OUT-1:0] INV_DOUT      = '0
) (
  input logic               clk,
  input logic               rst_n,
  input logic               din,
  input logic               addr_en,
  input logic               out_en,
  input logic [ADDR_W-1:0]  addr_eff,
  input logic [NUM_OUT-1:0] dout
);
  logic               din_l, aen_l, oen_l;
  logic [NUM_OUT-1:0] dout_l;
  assign din_l  = din ^ INV_DIN;
  assign aen_l  = addr_en ^ INV_AEN;
  assign oen_l  = out_en ^ INV_OEN;
  assign dout_l = dout ^ INV_DOUT;

  p_idle_low_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (oen_l || !USE_OUT_HOLD) && !din_l |-> dout_l == '0);

  p_onehot_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (oen_l || !USE_OUT_HOLD) |-> $onehot0(dout_l));

  p_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (oen_l || !USE_OUT_HOLD) && (int'(addr_eff) >= NUM_OUT) |-> dout_l == '0);

  if (USE_ADDR_HOLD && ADDR_MODE == ADDR_LEVEL) begin : g_lvl
    p_addr_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (!aen_l && $past(!aen_l) && $past(rst_n)) |-> $stable(addr_eff));
  end

  if (USE_ADDR_HOLD && ADDR_MODE == ADDR_RISE) begin : g_rise
    p_addr_edge_r5: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $past(rst_n, 2) && !($past(aen_l) && !$past(aen_l, 2)))
      |-> $stable(addr_eff));
  end

  if (USE_OUT_HOLD) begin : g_oh
    p_out_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (!oen_l && $past(!oen_l) && $past(rst_n)) |-> $stable(dout));
    p_reset_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(!rst_n) && !oen_l) |-> dout_l == '0);
  end
endmodule

bind bdemux bdemux_chk #(
  .NUM_OUT(NUM_OUT), .ADDR_W(ADDR_W), .USE_ADDR_HOLD(USE_ADDR_HOLD),
  .USE_OUT_HOLD(USE_OUT_HOLD), .ADDR_MODE(ADDR_MODE), .INV_DIN(INV_DIN),
  .INV_AEN(INV_AEN), .INV_OEN(INV_OEN), .INV_DOUT(INV_DOUT)
) u_chk (
  .clk(clk), .rst_n(rst_n), .din(din), .addr_en(addr_en), .out_en(out_en),
  .addr_eff(addr_eff), .dout(dout)
);

// File: tb/test_bdemux.sv
module test_bdemux;
  import bdemux_pkg::*;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        din = 1'b0;
  logic [3:0]  addr = '0;
  logic        aen = 1'b0;
  logic        oen = 1'b0;
  logic [11:0] dout0;
  logic [15:0] dout1;

  int tests = 0;
  int fails = 0;
  bit done  = 1'b0;

  always #2.5 clk = ~clk;

  // primary: level mode, both holds, no inversion, 12 outputs
  bdemux i_bdemux (
    .clk(clk), .rst_n(rst_n), .din(din), .addr(addr),
    .addr_en(aen), .out_en(oen), .dout(dout0)
  );

  // variant: rising mode, output hold bypassed, inverted data and low four outputs
  bdemux #(
    .NUM_OUT(16), .ADDR_W(4), .USE_OUT_HOLD(1'b0), .ADDR_MODE(ADDR_RISE),
    .INV_DIN(1'b1), .INV_DOUT(16'h000F)
  ) i_bdemux_alt (
    .clk(clk), .rst_n(rst_n), .din(din), .addr(addr),
    .addr_en(aen), .out_en(oen), .dout(dout1)
  );

  typedef struct {
    logic [11:0] e0;
    logic [15:0] e1;
    string       t0;
    string       t1;
  } item_t;
  item_t sb[$];

  // bench-side model state, derived from the requirements
  logic [3:0]  m0_aq, m1_aq;
  logic [11:0] m0_oq, m0_live;
  logic        m1_pen;

  task automatic step(input logic r, input logic d, input logic [3:0] a,
                      input logic ae, input logic oe, input string t0, input string t1);
    item_t it;
    logic [3:0] ea0;
    @(posedge clk);
    if (!rst_n) begin // R9
      m0_aq = '0; m0_oq = '0; m1_aq = '0; m1_pen = 1'b0;
    end else begin
      if (aen) m0_aq = addr;
      if (oen) m0_oq = m0_live;
      if (aen && !m1_pen) m1_aq = addr;
      m1_pen = aen;
    end
    #1;
    rst_n = r; din = d; addr = a; aen = ae; oen = oe;
    ea0     = aen ? addr : m0_aq;
    m0_live = (din && ea0 < 4'd12) ? (12'd1 << ea0) : 12'd0;
    it.e0   = oen ? m0_live : m0_oq;
    it.e1   = ((!din) ? (16'd1 << m1_aq) : 16'd0) ^ 16'h000F;
    it.t0   = t0;
    it.t1   = t1;
    sb.push_back(it);
  endtask

  always @(negedge clk) begin
    if (sb.size() > 0) begin
      item_t it;
      it = sb.pop_front();
      tests += 2;
      if (dout0 !== it.e0) begin
        fails++;
        $display("FAIL %s primary: got %h expected %h", it.t0, dout0, it.e0);
      end
      if (dout1 !== it.e1) begin
        fails++;
        $display("FAIL %s variant: got %h expected %h", it.t1, dout1, it.e1);
      end
    end
  end

  initial begin
    m0_aq = '0; m0_oq = '0; m0_live = '0; m1_aq = '0; m1_pen = 1'b0;
    // reset with both enables low: held state visible
    step(0, 0, 4'd0, 0, 0, "R9", "R9");
    step(0, 1, 4'd7, 0, 0, "R9", "R8");
    step(1, 1, 4'd7, 0, 0, "R9", "R8");
    // sweep with data high: selection and out-of-range blanking
    for (int i = 0; i < 16; i++)
      step(1, 1, 4'(i), 1, 1, (i < 12) ? "R2" : "R3", "R5");
    // sweep with data low
    for (int i = 0; i < 16; i++)
      step(1, 0, 4'(i), 1, 1, "R1", "R8");
    // rising-mode capture: drop then raise address enable
    step(1, 0, 4'd3, 0, 1, "R4", "R5");
    step(1, 0, 4'd9, 1, 1, "R1", "R5");
    step(1, 0, 4'd2, 1, 1, "R1", "R5");
    step(1, 0, 4'd2, 1, 1, "R1", "R5");
    // level-mode hold: load 5, then move address under a low enable
    step(1, 1, 4'd5, 1, 1, "R2", "R5");
    step(1, 1, 4'd9, 0, 1, "R4", "R5");
    step(1, 1, 4'd1, 0, 1, "R4", "R5");
    step(1, 1, 4'd14, 0, 1, "R4", "R5");
    // output hold: freeze pattern, change data and address
    step(1, 1, 4'd6, 1, 1, "R2", "R7");
    step(1, 0, 4'd6, 1, 0, "R6", "R7");
    step(1, 1, 4'd2, 1, 0, "R6", "R7");
    step(1, 1, 4'd13, 1, 0, "R6", "R7");
    step(1, 1, 4'd2, 1, 1, "R6", "R7");
    // reset mid-run then hold both
    step(0, 1, 4'd4, 0, 0, "R9", "R9");
    step(1, 1, 4'd4, 0, 0, "R9", "R9");
    step(1, 1, 4'd4, 0, 0, "R9", "R9");
    // mixed pseudo-random traffic
    for (int i = 0; i < 200; i++)
      step(1, 1'($urandom), 4'($urandom), 1'($urandom), 1'($urandom),
           "R1/R2/R3/R4/R6", "R5/R7/R8");
    @(posedge clk);
    @(negedge clk);
    @(negedge clk);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule